// File: doc/BRIEF.md
# Capture/Reload Timer with Baud Mode

This block is a 16-bit up-counter paired with a 16-bit reload/capture register and a small control register. It increments on every clock or on each falling edge of an external count input, and it works in one of three modes. In reload mode an overflow, or a trigger edge, loads the counter from the reload register. In capture mode a trigger edge copies the running count into that register. In baud mode the overflow becomes a periodic one-cycle tick for a serial port.

Software reaches the three registers through a simple write-strobe/address/data port with a combinational read path. Both external inputs pass through a two-flop synchronizer and a falling-edge detector. The trigger input can be inverted before synchronization. Two sticky flags report overflow and trigger events. Software clears each flag by writing a 1 to its bit.

Top module: `cap_reload_timer`

## Requirements
- R1: Address 0 is control, 1 is the counter, 2 is the reload/capture register, and 3 reads as zero. Control bit 0 is run. Bit 1 selects external counting. Bit 2 selects capture mode. Bit 3 enables the trigger. Bit 4 is receive-baud and bit 5 is transmit-baud. Bit 6 inverts the trigger. Bit 7 is the overflow flag and bit 8 is the trigger flag; higher bits read zero. After reset every register and output is zero.
- R2: With run=1 and bit 1=0 the counter rises by one per clock. With run=0 it holds, apart from register writes and trigger reloads.
- R3: With bit 1=1 the counter rises by one per falling edge of count_in, seen through two synchronizing flops. The new value appears after the third rising clock edge that follows the input fall.
- R4: In capture mode outside baud mode, with the trigger enabled, each trigger falling edge copies the counter into the reload/capture register. The counter is left unchanged.
- R5: In reload mode (bit 2=0) outside baud mode, an overflow loads the counter from the reload register. With the trigger enabled, a trigger falling edge also loads it, even when run=0.
- R6: With bit 3=0 a trigger edge causes no capture, no reload and no trigger flag.
- R7: If bit 4 or bit 5 is set, bit 2 is ignored and each overflow reloads the counter. Trigger edges neither capture nor reload, and the overflow flag is not set. baud_tick_o is high for exactly the one cycle in which the reloaded value is first visible.
- R8: Outside baud mode, an increment from 0xFFFF sets the overflow flag. In capture mode the counter then reads 0x0000.
- R9: Each trigger falling edge sets the trigger flag when bit 3=1, in every mode including baud mode.
- R10: Writing control with bit 7 or bit 8 equal to 1 clears that flag, and writing 0 leaves it unchanged. A hardware set in the same cycle wins over the clear.
- R11: With bit 6=1 the trigger is inverted before edge detection, so a rising edge on trig_in acts as the trigger.
- R12: A register write to the counter or to the reload/capture register takes priority over any hardware update of that register in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for reg_addr (combinational) |
| count_in | input | 1 | External count input, falling edges counted |
| trig_in | input | 1 | External capture/reload trigger |
| ovf_flag_o | output | 1 | Sticky overflow flag |
| trig_flag_o | output | 1 | Sticky trigger flag |
| baud_tick_o | output | 1 | One-cycle pulse per overflow in baud mode |

## Verification
On every cycle, the embedded assertions check these rules:
- a stopped counter holds its value;
- a trigger edge captures the count or loads the reload value, according to the mode;
- a counter write wins over the hardware update in the same cycle;
- each baud tick lines up with a reload;
- the flag set and clear rules are followed;
- a detected edge lasts exactly one cycle.

Only the bench scenarios show the longer-running behaviour:
- exact counts over long runs through overflow in each mode;
- the three-cycle latency of the external count path;
- trigger polarity inversion;
- the baud tick count;
- a reload-register write that collides with a capture.

// File: rtl/crt_pkg.sv
package crt_pkg;

    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_CNT  = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_RLD  = 2'd2;

    localparam int CTRL_BITS    = 7;
    localparam int OVF_FLAG_BIT = 7;
    localparam int TRG_FLAG_BIT = 8;
    localparam int CTRL_RD_W    = 9;

    // Packed control word; first field is the most significant bit (bit 6).
    typedef struct packed {
        logic trig_inv;
        logic tx_baud;
        logic rx_baud;
        logic trig_en;
        logic cap_sel;
        logic ext_cnt;
        logic run;
    } crt_ctrl_t;

endpackage

// File: rtl/crt_edge_sync.sv
module crt_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic fall_o
);
    localparam int SH_W = STAGES + 1;

    logic [SH_W-1:0] sh_d, sh_q;

    always_comb begin
        sh_d   = {sh_q[SH_W-2:0], din};
        fall_o = sh_q[SH_W-1] & ~sh_q[SH_W-2];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    // R3: a detected edge lasts exactly one cycle
    assert_single_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fall_o |=> !fall_o);

endmodule

// File: rtl/crt_ctrl.sv
module crt_ctrl
    import crt_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ctrl_we_i,
    input  logic [CTRL_RD_W-1:0] wdata_i,
    input  logic                 ovf_set_i,
    input  logic                 trig_set_i,
    output crt_ctrl_t            ctrl_o,
    output logic                 ovf_flag_o,
    output logic                 trig_flag_o
);
    typedef struct packed {
        crt_ctrl_t ctrl;
        logic      ovf;
        logic      trg;
    } ctrl_st_t;

    ctrl_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ctrl_we_i) begin
            st_d.ctrl = crt_ctrl_t'(wdata_i[CTRL_BITS-1:0]);
            if (wdata_i[OVF_FLAG_BIT]) st_d.ovf = 1'b0;
            if (wdata_i[TRG_FLAG_BIT]) st_d.trg = 1'b0;
        end
        // hardware set has priority over a software clear
        if (ovf_set_i)  st_d.ovf = 1'b1;
        if (trig_set_i) st_d.trg = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ctrl_o      = st_q.ctrl;
    assign ovf_flag_o  = st_q.ovf;
    assign trig_flag_o = st_q.trg;

    assert_ovf_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_set_i |=> ovf_flag_o);

    assert_trig_sets_R9: assert property (@(posedge clk) disable iff (!rst_n)
        trig_set_i |=> trig_flag_o);

    assert_trig_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_we_i && wdata_i[TRG_FLAG_BIT] && !trig_set_i) |=> !trig_flag_o);

    assert_ovf_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_we_i && !ovf_set_i) |=> $stable(ovf_flag_o));

endmodule

// File: rtl/crt_core.sv
module crt_core #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run_i,
    input  logic         ext_cnt_i,
    input  logic         cap_sel_i,
    input  logic         trig_en_i,
    input  logic         baud_i,
    input  logic         cnt_we_i,
    input  logic         rld_we_i,
    input  logic [W-1:0] wdata_i,
    input  logic         cnt_fall_i,
    input  logic         trig_fall_i,
    output logic [W-1:0] cnt_o,
    output logic [W-1:0] rld_o,
    output logic         ovf_set_o,
    output logic         trig_set_o,
    output logic         baud_tick_o
);
    typedef struct packed {
        logic [W-1:0] cnt;
        logic [W-1:0] rld;
        logic         tick;
    } core_st_t;

    core_st_t st_d, st_q;

    logic step, wrap, trig_hit, trig_act, reload_mode;

    always_comb begin
        step        = run_i & (ext_cnt_i ? cnt_fall_i : 1'b1);
        wrap        = step & (st_q.cnt == {W{1'b1}});
        trig_hit    = trig_en_i & trig_fall_i;
        trig_act    = trig_hit & ~baud_i;
        reload_mode = baud_i | ~cap_sel_i;

        st_d      = st_q;
        st_d.tick = wrap & baud_i;
        if (step)
            st_d.cnt = st_q.cnt + 1'b1;
        if (reload_mode && (wrap || trig_act))
            st_d.cnt = st_q.rld;
        if (!reload_mode && trig_act)
            st_d.rld = st_q.cnt;
        // software writes win over hardware updates
        if (cnt_we_i) st_d.cnt = wdata_i;
        if (rld_we_i) st_d.rld = wdata_i;

        ovf_set_o  = wrap & ~baud_i;
        trig_set_o = trig_hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_o       = st_q.cnt;
    assign rld_o       = st_q.rld;
    assign baud_tick_o = st_q.tick;

    assert_hold_stopped_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && !cnt_we_i && !(trig_en_i && trig_fall_i)) |=> cnt_o == $past(cnt_o));

    assert_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_sel_i && !baud_i && trig_en_i && trig_fall_i && !rld_we_i)
            |=> rld_o == $past(cnt_o));

    assert_trig_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!cap_sel_i && !baud_i && trig_en_i && trig_fall_i && !cnt_we_i)
            |=> cnt_o == $past(rld_o));

    assert_baud_reload_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (baud_tick_o && !$past(cnt_we_i)) |-> cnt_o == $past(rld_o));

    assert_write_wins_R12: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_we_i |=> cnt_o == $past(wdata_i));

endmodule

// File: rtl/cap_reload_timer.sv
module cap_reload_timer
    import crt_pkg::*;
#(
    parameter int W         = 16,
    parameter int SYNC_STGS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [W-1:0]      reg_wdata,
    output logic [W-1:0]      reg_rdata,
    input  logic              count_in,
    input  logic              trig_in,
    output logic              ovf_flag_o,
    output logic              trig_flag_o,
    output logic              baud_tick_o
);
    crt_ctrl_t ctrl;
    logic      cnt_fall, trig_fall, trig_raw;
    logic      ovf_set, trig_set;
    logic      ctrl_we, cnt_we, rld_we;
    logic [W-1:0] cnt, rld;

    assign ctrl_we  = reg_we && (reg_addr == ADDR_CTRL);
    assign cnt_we   = reg_we && (reg_addr == ADDR_CNT);
    assign rld_we   = reg_we && (reg_addr == ADDR_RLD);
    assign trig_raw = trig_in ^ ctrl.trig_inv;

    crt_edge_sync #(.STAGES(SYNC_STGS)) cnt_sync_i (
        .clk(clk), .rst_n(rst_n), .din(count_in), .fall_o(cnt_fall));

    crt_edge_sync #(.STAGES(SYNC_STGS)) trig_sync_i (
        .clk(clk), .rst_n(rst_n), .din(trig_raw), .fall_o(trig_fall));

    crt_ctrl ctrl_i (
        .clk(clk), .rst_n(rst_n), .ctrl_we_i(ctrl_we),
        .wdata_i(reg_wdata[CTRL_RD_W-1:0]),
        .ovf_set_i(ovf_set), .trig_set_i(trig_set),
        .ctrl_o(ctrl), .ovf_flag_o(ovf_flag_o), .trig_flag_o(trig_flag_o));

    crt_core #(.W(W)) core_i (
        .clk(clk), .rst_n(rst_n),
        .run_i(ctrl.run), .ext_cnt_i(ctrl.ext_cnt), .cap_sel_i(ctrl.cap_sel),
        .trig_en_i(ctrl.trig_en), .baud_i(ctrl.rx_baud | ctrl.tx_baud),
        .cnt_we_i(cnt_we), .rld_we_i(rld_we), .wdata_i(reg_wdata),
        .cnt_fall_i(cnt_fall), .trig_fall_i(trig_fall),
        .cnt_o(cnt), .rld_o(rld), .ovf_set_o(ovf_set), .trig_set_o(trig_set),
        .baud_tick_o(baud_tick_o));

    always_comb begin
        unique case (reg_addr)
            ADDR_CTRL: reg_rdata = {{(W-CTRL_RD_W){1'b0}}, trig_flag_o, ovf_flag_o, ctrl};
            ADDR_CNT:  reg_rdata = cnt;
            ADDR_RLD:  reg_rdata = rld;
            default:   reg_rdata = '0;
        endcase
    end

endmodule

// File: tb/cap_reload_timer_tb_top.sv
`timescale 1ns/1ps
module cap_reload_timer_tb_top;
    localparam logic [15:0] RUN = 16'h0001, EXT = 16'h0002, CAP = 16'h0004,
                            TEN = 16'h0008, RX  = 16'h0010, TX  = 16'h0020,
                            INV = 16'h0040, CLR_OVF = 16'h0080, CLR_TRG = 16'h0100;

    logic clk = 1'b0, rst_n = 1'b0, reg_we = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [15:0] reg_wdata = '0, reg_rdata;
    logic count_in = 1'b1, trig_in = 1'b1;
    logic ovf_flag_o, trig_flag_o, baud_tick_o;

    int n_checks = 0, n_err = 0, baud_seen = 0;

    always #4 clk = ~clk;

    cap_reload_timer dut_i (.clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .count_in(count_in), .trig_in(trig_in),
        .ovf_flag_o(ovf_flag_o), .trig_flag_o(trig_flag_o), .baud_tick_o(baud_tick_o));

    always @(negedge clk) if (rst_n && baud_tick_o) baud_seen++;

    typedef struct packed {
        logic [15:0] ctrl;
        logic [15:0] init;
        logic [15:0] rld;
        logic [15:0] cycles;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{RUN,            16'hFFF0, 16'h1234, 16'd20},
        '{RUN | CAP,      16'hFFFE, 16'h5555, 16'd5},
        '{RUN | CAP | RX, 16'hFFFC, 16'hFFF0, 16'd30},
        '{RUN | TX,       16'hFFF8, 16'hFFFA, 16'd25},
        '{RUN,            16'h0000, 16'h9999, 16'd9},
        '{CAP,            16'h4321, 16'h0000, 16'd12}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic trig_pulse(input logic idle);
        trig_in = ~idle;
        repeat (4) @(negedge clk);
        trig_in = idle;
        repeat (3) @(negedge clk);
    endtask

    task automatic model(input logic [15:0] ctrl, init, rld, input int ticks,
                         output logic [15:0] c, output logic ovf, output int bauds);
        logic baud, reload;
        baud = (ctrl & (RX | TX)) != 0;
        reload = baud || ((ctrl & CAP) == 0);
        c = init; ovf = 1'b0; bauds = 0;
        for (int i = 0; i < ticks; i++) begin
            if (c == 16'hFFFF) begin
                c = reload ? rld : 16'h0000;
                if (baud) bauds++; else ovf = 1'b1;
            end else c = c + 1'b1;
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", n_checks, n_err);
        $finish;
    end

    initial begin : main
        logic [15:0] v, ec;
        logic eo;
        int eb, ticks;
        repeat (3) @(negedge clk);
        // R1: reset state
        for (int a = 0; a < 4; a++) begin
            rd(a[1:0], v);
            chk("R1 reset read", v, 0);
        end
        chk("R1 reset outputs", {ovf_flag_o, trig_flag_o, baud_tick_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        wr(2'd3, 16'hFFFF);
        rd(2'd3, v); chk("R1 unused address", v, 0);

        // table-driven runs: R2 R5 R7 R8
        for (int k = 0; k < 6; k++) begin
            wr(2'd0, CLR_OVF | CLR_TRG);
            wr(2'd1, VECS[k].init);
            wr(2'd2, VECS[k].rld);
            baud_seen = 0;
            wr(2'd0, VECS[k].ctrl);
            repeat (int'(VECS[k].cycles)) @(negedge clk);
            wr(2'd0, 16'h0000);
            @(negedge clk);
            ticks = ((VECS[k].ctrl & RUN) != 0) ? int'(VECS[k].cycles) + 1 : 0;
            model(VECS[k].ctrl, VECS[k].init, VECS[k].rld, ticks, ec, eo, eb);
            rd(2'd1, v);
            chk($sformatf("R2 R5 R7 R8 vec %0d count", k), v, ec);
            chk($sformatf("R8 vec %0d overflow flag", k), ovf_flag_o, eo);
            chk($sformatf("R7 vec %0d baud ticks", k), baud_seen, eb);
        end
        wr(2'd0, CLR_OVF | CLR_TRG);

        // R3: external count latency and counting
        wr(2'd1, 16'h0000);
        wr(2'd0, RUN | EXT);
        count_in = 1'b0;
        @(negedge clk); rd(2'd1, v); chk("R3 after 1 edge", v, 0);
        @(negedge clk); rd(2'd1, v); chk("R3 after 2 edges", v, 0);
        @(negedge clk); rd(2'd1, v); chk("R3 after 3 edges", v, 1);
        count_in = 1'b1;
        repeat (3) @(negedge clk);
        for (int p = 0; p < 2; p++) begin
            count_in = 1'b0; repeat (3) @(negedge clk);
            count_in = 1'b1; repeat (3) @(negedge clk);
        end
        rd(2'd1, v); chk("R3 three edges counted", v, 3);
        wr(2'd0, 16'h0000);

        // R12 + R2: counter write beats increment
        wr(2'd0, RUN);
        wr(2'd1, 16'h0042);
        rd(2'd1, v); chk("R12 write wins over increment", v, 16'h0042);
        @(negedge clk);
        rd(2'd1, v); chk("R2 increments per clock", v, 16'h0043);
        wr(2'd0, 16'h0000);

        // R6: trigger disabled
        wr(2'd0, CAP);
        wr(2'd1, 16'h3333); wr(2'd2, 16'h0000);
        trig_pulse(1'b1);
        rd(2'd2, v); chk("R6 no capture when disabled", v, 0);
        chk("R6 no flag when disabled", trig_flag_o, 0);

        // R4: capture
        wr(2'd0, CAP | TEN);
        wr(2'd1, 16'hABCD);
        trig_pulse(1'b1);
        rd(2'd2, v); chk("R4 captured value", v, 16'hABCD);
        rd(2'd1, v); chk("R4 counter unchanged", v, 16'hABCD);
        chk("R9 flag on capture", trig_flag_o, 1);
        // R10: writing 0 keeps the flag, writing 1 clears it
        wr(2'd0, CAP | TEN);
        chk("R10 zero write keeps flag", trig_flag_o, 1);
        wr(2'd0, CAP | TEN | CLR_TRG);
        chk("R10 one write clears flag", trig_flag_o, 0);

        // R5: trigger reload while stopped
        wr(2'd0, TEN);
        wr(2'd1, 16'h0100); wr(2'd2, 16'h7777);
        trig_pulse(1'b1);
        rd(2'd1, v); chk("R5 trigger reload", v, 16'h7777);
        wr(2'd0, CLR_TRG);

        // R7 + R9: baud mode ignores trigger for data, flag still set
        wr(2'd0, RX | TEN | CAP);
        wr(2'd1, 16'h0200); wr(2'd2, 16'h0300);
        trig_pulse(1'b1);
        rd(2'd1, v); chk("R7 baud no reload", v, 16'h0200);
        rd(2'd2, v); chk("R7 baud no capture", v, 16'h0300);
        chk("R9 flag in baud mode", trig_flag_o, 1);
        wr(2'd0, CLR_TRG);

        // R11: inverted trigger, rising pin edge captures
        wr(2'd0, CAP);
        trig_in = 1'b0; repeat (3) @(negedge clk);
        wr(2'd0, CAP | INV); repeat (3) @(negedge clk);
        wr(2'd0, CAP | INV | TEN);
        wr(2'd1, 16'h0BEE); wr(2'd2, 16'h0000);
        trig_pulse(1'b0);
        rd(2'd2, v); chk("R11 inverted trigger captures", v, 16'h0BEE);
        trig_in = 1'b1;
        wr(2'd0, CAP | CLR_TRG); repeat (3) @(negedge clk);

        // R12: reload-register write collides with capture
        wr(2'd0, CAP | TEN);
        wr(2'd1, 16'h1111); wr(2'd2, 16'h0000);
        trig_in = 1'b0;
        @(negedge clk); @(negedge clk);
        wr(2'd2, 16'h2468);
        rd(2'd2, v); chk("R12 write wins over capture", v, 16'h2468);
        chk("R9 flag on colliding edge", trig_flag_o, 1);
        trig_in = 1'b1; repeat (3) @(negedge clk);

        $display("  CHECKS %0d ERRORS %0d", n_checks, n_err);
        $finish;
    end
endmodule